// File: doc/BRIEF.md
# Thread Context Swap Engine

This block moves a core's thread control state between its live register file and memory so that a thread switch never stalls the core's pipeline. An agent writes the address of the incoming thread's state block into a pointer register. That agent may be the core itself, or another agent writing over the memory-mapped register port. The engine then reads that block from memory in the background into a shadow buffer. It keeps the old thread's address so that it can write the old state back later.

When the core issues a resume command, the engine exchanges the shadow buffer and the live registers in a single cycle and pulses a completion signal. It then drains the old thread's state, which now sits in the shadow buffer, back to the old address. No store is issued before all of the inbound data has arrived. Every transfer is a half-line of 256 bits, and each 64-byte line moves as two independent operations. The write side obeys a ready signal, so a downstream request queue cannot be flooded.

The live registers stay readable and writable through the same register port at all times. This lets a remote agent inspect a core that has stopped responding.

Top module: `ctx_swap_engine`

## Requirements
- R1: After reset the engine is idle, status reads 0, the current-thread pointer reads 0, the live state is all zeros and no memory request is valid.
- R2: A write to control address 0 with a 64-byte-aligned value while idle arms a switch. Status bit 0 (busy) goes high, and read requests are issued at pointer + 32·k for k = 0..7, in ascending order.
- R3: A pointer write whose low 6 bits are not all zero, made while idle, is ignored. No memory request is made and the next-pointer register is unchanged. Sticky status bit 2 is set.
- R4: A pointer write made while busy is rejected, leaves the next-pointer register unchanged, and sets sticky status bit 3.
- R5: Read responses fill the shadow buffer in request order. Status bit 1 (staged) goes high once all 8 have arrived. No write request is issued before all 8 responses have arrived.
- R6: A resume request is accepted only while staged and is otherwise held off. `res_done` pulses in the cycle after acceptance. From that cycle, live word w (bits 32w+31..32w) equals the memory word at next-pointer + 4w.
- R7: A resume request while no switch is armed has no effect: no done pulse, and the live state and current pointer are unchanged.
- R8: At the swap the current pointer (control address 1) takes the next-pointer value. The engine then writes 8 half-lines to old-pointer + 32·h. Half h carries the pre-swap live words 8h..8h+7, lowest word in the lowest bits.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request address, direction and data hold steady. Each half-line is accepted exactly once.
- R10: Busy drops after the last write half is accepted. A new aligned pointer write is accepted after that.
- R11: With address bit 6 set, bits 5..0 select live word 0..63 for read or write. With bit 6 clear, the low two bits select next-pointer (0), current pointer (1) or status (2). The read data is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address (bit 6 selects live words) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted when high with valid |
| mem_req_write | output | 1 | 1 = write half-line, 0 = read half-line |
| mem_req_addr | output | 32 | Byte address of the half-line |
| mem_req_wdata | output | 256 | Write data |
| mem_rsp_valid | input | 1 | Read response valid (in request order) |
| mem_rsp_data | input | 256 | Read response data |
| res_req | input | 1 | Resume request, held until done |
| res_done | output | 1 | One-cycle pulse when the swap has happened |
| live_state | output | 2048 | Live thread state seen by the core |

## Verification
The bench sweeps six switches that combine stalled and free-running memory with a resume raised early or raised only after staging. An engine that let stores start early would show write traffic before staging, and one that swapped before the last response arrived would load a stale half into the live state. Rejected pointer writes are tried both misaligned while idle and aligned while busy. A design that let them through would change the next-pointer register or start memory traffic. A resume made while idle is checked for a phantom done pulse. Backpressure every third cycle catches a design that drops or repeats a half-line during the writeback.

// File: rtl/ctx_swap_pkg.sv
package ctx_swap_pkg;
  typedef enum logic [1:0] {
    CS_IDLE   = 2'd0,
    CS_FETCH  = 2'd1,
    CS_STAGED = 2'd2,
    CS_DRAIN  = 2'd3
  } cs_state_e;

  localparam logic [1:0] CSR_NEXT = 2'd0;
  localparam logic [1:0] CSR_CUR  = 2'd1;
  localparam logic [1:0] CSR_STAT = 2'd2;
endpackage

// File: rtl/ctx_swap_ctrl.sv
module ctx_swap_ctrl import ctx_swap_pkg::*; #(
  parameter int unsigned W          = 32,
  parameter int unsigned NHALF      = 8,
  parameter int unsigned HALF_BYTES = 32,
  localparam int unsigned IDX_W     = $clog2(NHALF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [W-1:0]     arm_ptr,
  input  logic             res_req,
  input  logic             req_ready,
  input  logic             rsp_valid,
  output cs_state_e        state,
  output logic             req_valid,
  output logic             req_write,
  output logic [W-1:0]     req_addr,
  output logic [IDX_W-1:0] req_idx,
  output logic             rsp_take,
  output logic [IDX_W-1:0] rsp_idx,
  output logic             swap,
  output logic             res_done,
  output logic [W-1:0]     next_ptr,
  output logic [W-1:0]     cur_ptr
);
  localparam int unsigned CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NHALF - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NHALF);

  cs_state_e        state_q, state_d;
  logic [CNT_W-1:0] req_cnt_q, req_cnt_d;
  logic [CNT_W-1:0] rsp_cnt_q, rsp_cnt_d;
  logic             done_q;
  logic [W-1:0]     in_ptr_q, out_ptr_q, cur_ptr_q;
  logic             req_fire;
  logic             load_en;
  logic [W-1:0]     base;

  always_comb begin
    state_d   = state_q;
    req_cnt_d = req_cnt_q;
    rsp_cnt_d = rsp_cnt_q;
    req_valid = ((state_q == CS_FETCH) && (req_cnt_q < CNT_FULL)) ||
                (state_q == CS_DRAIN);
    req_fire  = req_valid && req_ready;
    rsp_take  = (state_q == CS_FETCH) && rsp_valid;
    swap      = (state_q == CS_STAGED) && res_req;
    load_en   = (state_q == CS_IDLE) && arm;
    unique case (state_q)
      CS_IDLE: begin
        if (arm) begin
          state_d   = CS_FETCH;
          req_cnt_d = '0;
          rsp_cnt_d = '0;
        end
      end
      CS_FETCH: begin
        if (req_fire) req_cnt_d = req_cnt_q + CNT_ONE;
        if (rsp_take) begin
          rsp_cnt_d = rsp_cnt_q + CNT_ONE;
          if (rsp_cnt_q == CNT_LAST) state_d = CS_STAGED;
        end
      end
      CS_STAGED: begin
        if (res_req) begin
          state_d   = CS_DRAIN;
          req_cnt_d = '0;
        end
      end
      CS_DRAIN: begin
        if (req_fire) begin
          req_cnt_d = req_cnt_q + CNT_ONE;
          if (req_cnt_q == CNT_LAST) state_d = CS_IDLE;
        end
      end
      default: state_d = CS_IDLE;
    endcase
  end

  assign req_write = (state_q == CS_DRAIN);
  assign base      = req_write ? out_ptr_q : in_ptr_q;
  assign req_addr  = base + W'(req_cnt_q) * W'(HALF_BYTES);
  assign req_idx   = req_cnt_q[IDX_W-1:0];
  assign rsp_idx   = rsp_cnt_q[IDX_W-1:0];
  assign state     = state_q;
  assign res_done  = done_q;
  assign next_ptr  = in_ptr_q;
  assign cur_ptr   = cur_ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= CS_IDLE;
      req_cnt_q <= '0;
      rsp_cnt_q <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      req_cnt_q <= req_cnt_d;
      rsp_cnt_q <= rsp_cnt_d;
      done_q    <= swap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_ptr_q  <= '0;
      out_ptr_q <= '0;
    end else if (load_en) begin
      in_ptr_q  <= arm_ptr;
      out_ptr_q <= cur_ptr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ptr_q <= '0;
    end else if (swap) begin
      cur_ptr_q <= in_ptr_q;
    end
  end
endmodule

// File: rtl/ctx_swap_store.sv
module ctx_swap_store #(
  parameter int unsigned STATE_W = 2048,
  parameter int unsigned HALF_W  = 256,
  parameter int unsigned W       = 32,
  localparam int unsigned NHALF  = STATE_W / HALF_W,
  localparam int unsigned NWORDS = STATE_W / W,
  localparam int unsigned IDX_W  = $clog2(NHALF),
  localparam int unsigned WIDX_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [HALF_W-1:0] fill_data,
  input  logic              swap,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_idx,
  input  logic [W-1:0]      wr_data,
  input  logic [WIDX_W-1:0] rd_idx,
  output logic [W-1:0]      rd_data,
  input  logic [IDX_W-1:0]  out_idx,
  output logic [HALF_W-1:0] out_data,
  output logic [STATE_W-1:0] live
);
  logic [STATE_W-1:0] live_q, live_d;
  logic [STATE_W-1:0] shad_q, shad_d;
  logic               live_en, shad_en;

  always_comb begin
    live_d  = live_q;
    shad_d  = shad_q;
    live_en = wr_en || swap;
    shad_en = fill_en || swap;
    if (fill_en) shad_d[int'(fill_idx)*HALF_W +: HALF_W] = fill_data;
    if (wr_en)   live_d[int'(wr_idx)*W +: W] = wr_data;
    if (swap) begin
      live_d = shad_q;
      shad_d = live_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (live_en) begin
      live_q <= live_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shad_q <= '0;
    end else if (shad_en) begin
      shad_q <= shad_d;
    end
  end

  assign rd_data  = live_q[int'(rd_idx)*W +: W];
  assign out_data = shad_q[int'(out_idx)*HALF_W +: HALF_W];
  assign live     = live_q;
endmodule

// File: rtl/ctx_swap_engine.sv
module ctx_swap_engine import ctx_swap_pkg::*; #(
  parameter int unsigned W          = 32,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned NLINES     = 4,
  parameter int unsigned HALF_W     = 256,
  localparam int unsigned STATE_W   = NLINES * LINE_BYTES * 8,
  localparam int unsigned NWORDS    = STATE_W / W,
  localparam int unsigned RA_W      = $clog2(NWORDS) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic [W-1:0]       reg_wdata,
  output logic [W-1:0]       reg_rdata,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [W-1:0]       mem_req_addr,
  output logic [HALF_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [HALF_W-1:0]  mem_rsp_data,
  input  logic               res_req,
  output logic               res_done,
  output logic [STATE_W-1:0] live_state
);
  localparam int unsigned WIDX_W     = RA_W - 1;
  localparam int unsigned ALIGN_W    = $clog2(LINE_BYTES);
  localparam int unsigned HALF_BYTES = HALF_W / 8;
  localparam int unsigned NHALF      = STATE_W / HALF_W;
  localparam int unsigned IDX_W      = $clog2(NHALF);

  logic rst_meta, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_i  <= rst_meta;
    end
  end

  cs_state_e        state;
  logic             busy, staged;
  logic             is_live, ptr_wr, aligned;
  logic             arm, mis_set, ovr_set;
  logic             mis_q, ovr_q;
  logic [1:0]       csr_sel;
  logic             rsp_take, swap;
  logic [IDX_W-1:0] req_idx, rsp_idx;
  logic [W-1:0]     next_ptr, cur_ptr, live_rd;
  logic             live_wr;

  assign is_live = reg_addr[RA_W-1];
  assign csr_sel = reg_addr[1:0];
  assign ptr_wr  = reg_wr && !is_live && (csr_sel == CSR_NEXT);
  assign aligned = (reg_wdata[ALIGN_W-1:0] == '0);
  assign busy    = (state != CS_IDLE);
  assign staged  = (state == CS_STAGED);
  assign arm     = ptr_wr && !busy && aligned;
  assign mis_set = ptr_wr && !busy && !aligned;
  assign ovr_set = ptr_wr && busy;
  assign live_wr = reg_wr && is_live;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mis_q <= 1'b0;
    end else if (mis_set) begin
      mis_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ovr_q <= 1'b0;
    end else if (ovr_set) begin
      ovr_q <= 1'b1;
    end
  end

  ctx_swap_ctrl #(
    .W(W), .NHALF(NHALF), .HALF_BYTES(HALF_BYTES)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .arm      (arm),
    .arm_ptr  (reg_wdata),
    .res_req  (res_req),
    .req_ready(mem_req_ready),
    .rsp_valid(mem_rsp_valid),
    .state    (state),
    .req_valid(mem_req_valid),
    .req_write(mem_req_write),
    .req_addr (mem_req_addr),
    .req_idx  (req_idx),
    .rsp_take (rsp_take),
    .rsp_idx  (rsp_idx),
    .swap     (swap),
    .res_done (res_done),
    .next_ptr (next_ptr),
    .cur_ptr  (cur_ptr)
  );

  ctx_swap_store #(
    .STATE_W(STATE_W), .HALF_W(HALF_W), .W(W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .fill_en  (rsp_take),
    .fill_idx (rsp_idx),
    .fill_data(mem_rsp_data),
    .swap     (swap),
    .wr_en    (live_wr),
    .wr_idx   (reg_addr[WIDX_W-1:0]),
    .wr_data  (reg_wdata),
    .rd_idx   (reg_addr[WIDX_W-1:0]),
    .rd_data  (live_rd),
    .out_idx  (req_idx),
    .out_data (mem_req_wdata),
    .live     (live_state)
  );

  always_comb begin
    reg_rdata = '0;
    if (is_live) begin
      reg_rdata = live_rd;
    end else begin
      unique case (csr_sel)
        CSR_NEXT: reg_rdata = next_ptr;
        CSR_CUR:  reg_rdata = cur_ptr;
        CSR_STAT: reg_rdata = W'({ovr_q, mis_q, staged, busy});
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ctx_swap_engine_chk.sv
module ctx_swap_engine_chk #(
  parameter int unsigned W      = 32,
  parameter int unsigned HALF_W = 256,
  parameter int unsigned NHALF  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              busy,
  input logic              staged,
  input logic              res_req,
  input logic              res_done,
  input logic [W-1:0]      cur_ptr,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [W-1:0]      mem_req_addr,
  input logic [HALF_W-1:0] mem_req_wdata,
  input logic              mem_rsp_valid
);
  localparam int unsigned HB_W = $clog2(HALF_W / 8);

  logic [7:0] rsp_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_seen <= '0;
    end else if (!busy) begin
      rsp_seen <= '0;
    end else if (mem_rsp_valid) begin
      rsp_seen <= rsp_seen + 8'd1;
    end
  end

  a_r2_arm_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr));

  a_r2_half_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[HB_W-1:0] == '0));

  a_r5_store_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (rsp_seen == 8'(NHALF)));

  a_r6_done_after_staged: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> $past(staged && res_req));

  a_r8_ptr_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_ptr) |-> res_done);

  a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
       $stable(mem_req_wdata)));
endmodule

bind ctx_swap_engine ctx_swap_engine_chk #(
  .W(W), .HALF_W(HALF_W), .NHALF(NHALF)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n_i),
  .reg_wr       (reg_wr),
  .busy         (busy),
  .staged       (staged),
  .res_req      (res_req),
  .res_done     (res_done),
  .cur_ptr      (cur_ptr),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write),
  .mem_req_addr (mem_req_addr),
  .mem_req_wdata(mem_req_wdata),
  .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/test_ctx_swap_engine.sv
module test_ctx_swap_engine;
  localparam int CLK_P = 10;
  localparam int SW    = 2048;
  localparam int HW    = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [6:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          mem_req_valid, mem_req_write;
  logic          mem_req_ready = 1'b1;
  logic [31:0]   mem_req_addr;
  logic [HW-1:0] mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [HW-1:0] mem_rsp_data = '0;
  logic          res_req = 1'b0;
  logic          res_done;
  logic [SW-1:0] live_state;

  always #(CLK_P/2) clk = ~clk;

  ctx_swap_engine i_ctx_swap_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_req(res_req), .res_done(res_done),
    .live_state(live_state)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;
  int bp_mode = 0;
  int cyc = 0;
  int rd_n = 0, wr_n = 0, rsp_n = 0;
  logic          pend_v = 1'b0;
  logic [HW-1:0] pend_d = '0;
  logic [31:0]   rd_addr [0:15];
  logic [31:0]   wr_addr [0:15];
  logic [HW-1:0] wr_data [0:15];
  logic [SW-1:0] exp_live = '0;
  logic [31:0]   exp_cur = '0;

  function automatic logic [31:0] memword(logic [31:0] a);
    return a ^ 32'h5A3C_0000;
  endfunction

  function automatic logic [HW-1:0] half_at(logic [31:0] a);
    logic [HW-1:0] h;
    for (int j = 0; j < 8; j++) h[j*32 +: 32] = memword(a + 32'(4*j));
    return h;
  endfunction

  function automatic logic [SW-1:0] block_at(logic [31:0] a);
    logic [SW-1:0] b;
    for (int k = 0; k < 8; k++) b[k*HW +: HW] = half_at(a + 32'(32*k));
    return b;
  endfunction

  // memory model: decisions at the falling edge, handshakes at the next rising edge
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = pend_v;
    mem_rsp_data  = pend_d;
    if (pend_v) rsp_n++;
    pend_v = 1'b0;
    mem_req_ready = (bp_mode == 0) || (cyc % 3 != 0);
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        if (wr_n < 16) begin
          wr_addr[wr_n] = mem_req_addr;
          wr_data[wr_n] = mem_req_wdata;
        end
        wr_n++;
      end else begin
        if (rd_n < 16) rd_addr[rd_n] = mem_req_addr;
        rd_n++;
        pend_v = 1'b1;
        pend_d = half_at(mem_req_addr);
      end
    end
  end

  task automatic chk(input string tag, input logic [HW-1:0] act, input logic [HW-1:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic write_reg(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_status(input int bitpos, input logic val, input string tag);
    logic [31:0] s;
    bit ok = 0;
    for (int i = 0; i < 500; i++) begin
      read_reg(7'd2, s);
      if (s[bitpos] == val) begin ok = 1; break; end
    end
    chk(tag, HW'(ok), HW'(1));
  endtask

  task automatic wait_done(input string tag);
    bit ok = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (res_done) begin ok = 1; break; end
    end
    chk(tag, HW'(ok), HW'(1));
    res_req = 1'b0;
  endtask

  task automatic do_swap(input logic [31:0] ptr, input int bp, input bit early);
    logic [31:0] s, old_ptr;
    logic [SW-1:0] new_live;
    old_ptr = exp_cur;
    new_live = block_at(ptr);
    bp_mode = bp;
    rd_n = 0; wr_n = 0; rsp_n = 0;
    write_reg(7'd0, ptr);
    if (early) begin
      res_req = 1'b1;
      wait_done("R6 done seen (early resume)");
      chk("R6 all responses before done", HW'(rsp_n), HW'(8));
    end else begin
      read_reg(7'd2, s);
      chk("R2 busy after arm", HW'(s[0]), HW'(1));
      wait_status(1, 1'b1, "R5 staged reached");
      chk("R5 no store before swap", HW'(wr_n), HW'(0));
      write_reg(7'd0, ptr + 32'h0004_0000);
      read_reg(7'd2, s);
      chk("R4 overrun flag", HW'(s[3]), HW'(1));
      read_reg(7'd0, s);
      chk("R4 next pointer kept", HW'(s), HW'(ptr));
      res_req = 1'b1;
      wait_done("R6 done seen (late resume)");
    end
    for (int h = 0; h < 8; h++)
      chk("R6 live half after swap", live_state[h*HW +: HW], new_live[h*HW +: HW]);
    read_reg(7'd1, s);
    chk("R8 current pointer", HW'(s), HW'(ptr));
    read_reg({1'b1, 6'd9}, s);
    chk("R11 live word 9 readback", HW'(s), HW'(memword(ptr + 32'd36)));
    wait_status(0, 1'b0, "R10 busy drops");
    chk("R2 read count", HW'(rd_n), HW'(8));
    for (int k = 0; k < 8; k++)
      chk("R2 read address order", HW'(rd_addr[k]), HW'(ptr + 32'(32*k)));
    chk("R9 write count exact", HW'(wr_n), HW'(8));
    for (int k = 0; k < 8; k++) begin
      chk("R8 write address", HW'(wr_addr[k]), HW'(old_ptr + 32'(32*k)));
      chk("R8 write data", wr_data[k], exp_live[k*HW +: HW]);
    end
    exp_live = new_live;
    exp_cur  = ptr;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    read_reg(7'd2, s);  chk("R1 status", HW'(s), HW'(0));
    read_reg(7'd1, s);  chk("R1 current pointer", HW'(s), HW'(0));
    chk("R1 live state low", live_state[HW-1:0], '0);
    chk("R1 no request", HW'(mem_req_valid), HW'(0));

    // R11 live word access
    for (int w = 0; w < 64; w++) begin
      write_reg({1'b1, 6'(w)}, 32'h1000_0000 + 32'(w * 7));
      exp_live[w*32 +: 32] = 32'h1000_0000 + 32'(w * 7);
    end
    read_reg({1'b1, 6'd5}, s);  chk("R11 word 5", HW'(s), HW'(32'h1000_0023));
    read_reg({1'b1, 6'd63}, s); chk("R11 word 63", HW'(s), HW'(32'h1000_01B9));

    // R3 misaligned pointer
    write_reg(7'd0, 32'h0000_1010);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (mem_req_valid) seen = 1;
    end
    chk("R3 no memory traffic", HW'(seen), HW'(0));
    read_reg(7'd2, s);
    chk("R3 error flag set, idle", HW'(s[2:0]), HW'(3'b100));
    read_reg(7'd0, s);
    chk("R3 next pointer unchanged", HW'(s), HW'(0));

    // R7 resume while idle
    res_req = 1'b1;
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (res_done) seen = 1;
    end
    res_req = 1'b0;
    chk("R7 no done when idle", HW'(seen), HW'(0));
    chk("R7 live unchanged", live_state[HW-1:0], exp_live[HW-1:0]);
    read_reg(7'd1, s);
    chk("R7 current pointer unchanged", HW'(s), HW'(0));

    // sweep of switches over pointers, backpressure and resume timing
    for (int k = 0; k < 6; k++)
      do_swap(32'h0001_0000 + 32'(k) * 32'h440, k % 2, (k / 2) % 2 == 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule